// File: doc/BRIEF.md
# Processor Mode Register with DO-Loop Nesting Tracker

This block holds a 16-bit processor mode word and tracks how deeply hardware DO loops are nested. Software reads and writes the word through a simple register port. The configuration bits a write changes appear on the read port at once. They reach the effective-mode outputs only one instruction cycle later, so the instruction that writes a mode never runs under that mode. During reset the two lowest bits capture the mode-select pins. Every other bit clears.

Bit 15 of the word is the nesting flag. It pairs with a loop flag that the block drives out to the separate status register. The pair forms a small state machine with three named states: `LOOP_NONE` (flags 00), `LOOP_ONE` (flags 01) and `LOOP_TWO` (flags 11).

The transitions are:
- *enter* (`LOOP_NONE`→`LOOP_ONE`) on a DO start.
- *nest* (`LOOP_ONE`→`LOOP_TWO`) on a DO start, or on a register write with bit 15 set (this restores saved stack state).
- *unnest* (`LOOP_TWO`→`LOOP_ONE`) on a DO end, or on a write with bit 15 clear.
- *leave* (`LOOP_ONE`→`LOOP_NONE`) on a DO end.
- *overflow* (`LOOP_TWO`→`LOOP_TWO`) on a third DO start. This raises a sticky error.
- *reject* (`LOOP_NONE`→`LOOP_NONE`) on a write that sets bit 15 with no loop active. This pulses an error.

The flag pair 10 is never produced. One clock cycle is one instruction cycle.

Top module: `opmode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the word loads 0 except bit 1 = `mode_pin_b` and bit 0 = `mode_pin_a`. `eff_mode` takes the same value, the loop state becomes `LOOP_NONE`, and both error outputs go low.
- R2: Only bits 8, 6, 5, 4, 3, 1, 0 (mask 0x017B) are written from `reg_wr_data`. All other bits except 15 always read 0. A written value shows on `reg_rd_data` right after the write edge.
- R3: `eff_mode` shows the masked configuration bits one cycle later than `reg_rd_data` does. Its bit 15 is always 0.
- R4: `loop_status` = {`nest_flag`, `loop_flag`}: 00 no loop, 01 one loop, 11 two loops. The value 10 never appears. `reg_rd_data[15]` equals `nest_flag`.
- R5: A `do_start` moves `LOOP_NONE` to `LOOP_ONE` and `LOOP_ONE` to `LOOP_TWO`.
- R6: A `do_end` moves `LOOP_TWO` to `LOOP_ONE` and `LOOP_ONE` to `LOOP_NONE`. In `LOOP_NONE` it has no effect.
- R7: A `do_start` in `LOOP_TWO` leaves the state unchanged. It sets `nest_overflow`, which stays high until reset.
- R8: `rep_strobe` changes no output.
- R9: A write with bit 15 = 1 in `LOOP_ONE` moves to `LOOP_TWO`. A write with bit 15 = 0 in `LOOP_TWO` moves to `LOOP_ONE`.
- R10: A write with bit 15 = 1 in `LOOP_NONE` leaves the nesting flag at 0. It pulses `nest_illegal` high for the one cycle after the write edge. The write's other bits are still stored.
- R11: `do_start` and `do_end` together change no loop state. When either strobe is high, the bit 15 field of a write is ignored, but the write's other bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per period |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin_a | input | 1 | Mode-select pin captured into bit 0 at reset |
| mode_pin_b | input | 1 | Mode-select pin captured into bit 1 at reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 16 | Register write value |
| reg_rd_data | output | 16 | Architectural register value |
| do_start | input | 1 | DO loop begins |
| do_end | input | 1 | DO loop finishes |
| rep_strobe | input | 1 | Single-instruction repeat begins (no effect) |
| eff_mode | output | 16 | Configuration bits currently in force |
| loop_flag | output | 1 | Loop flag for the status register |
| nest_flag | output | 1 | Nesting flag (register bit 15) |
| loop_status | output | 2 | {nest_flag, loop_flag} |
| nest_overflow | output | 1 | Sticky: DO start attempted with two loops active |
| nest_illegal | output | 1 | One-cycle pulse: rejected nesting-flag write |

## Verification
A wrong loop state shows up the cycle after the faulty edge on `loop_status`, `nest_flag` and `reg_rd_data[15]`. A lost or extra transition stays visible until the next strobe or write repairs it. An early or late mode copy shows only on `eff_mode`, for exactly one cycle around each write. Because of that, every write is followed by an idle cycle in which both the old and the new effective values are sampled. Error outputs are compared every cycle: a stray `nest_illegal` lasts one cycle, and a wrongly set `nest_overflow` persists until reset.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
    localparam int          REG_W   = 16;
    localparam int          NL_BIT  = 15;
    localparam logic [15:0] CFG_MSK = 16'h017B;

    typedef enum logic [1:0] {
        LOOP_NONE = 2'b00,
        LOOP_ONE  = 2'b01,
        LOOP_TWO  = 2'b11
    } loop_state_t;
endpackage

// File: rtl/opmode_cfg_reg.sv
module opmode_cfg_reg #(
    parameter int          W   = 16,
    parameter logic [15:0] MSK = 16'h017B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin_a,
    input  logic         pin_b,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cfg_q,
    output logic [W-1:0] eff_q
);
    localparam logic [W-1:0] WMASK = MSK[W-1:0];

    logic [W-1:0] rst_val;

    always_comb begin
        rst_val    = '0;
        rst_val[0] = pin_a;
        rst_val[1] = pin_b;
    end

    // architectural copy: updated at the write edge
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= rst_val;
        else if (wr_en) cfg_q <= wr_data & WMASK;
    end

    // effective copy: trails the architectural copy by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) eff_q <= rst_val;
        else        eff_q <= cfg_q;
    end

    // R3: a write reaches the effective copy two edges after it is sampled
    a_r3_delayed_effect: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ##1 (eff_q == ($past(wr_data, 2) & WMASK)));
endmodule

// File: rtl/opmode_loop_fsm.sv
module opmode_loop_fsm
    import opmode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        do_start,
    input  logic        do_end,
    input  logic        rep_strobe,
    input  logic        wr_en,
    input  logic        wr_nl,
    output loop_state_t state_q,
    output logic        overflow_q,
    output logic        illegal_q
);
    loop_state_t state_d;
    logic        ovf_set;
    logic        ill_d;
    logic        only_start;
    logic        only_end;
    logic        nl_write;

    assign only_start = do_start && !do_end;
    assign only_end   = do_end && !do_start;
    assign nl_write   = wr_en && !do_start && !do_end;

    // next-state logic
    always_comb begin
        state_d = state_q;
        ovf_set = 1'b0;
        ill_d   = 1'b0;
        unique case (state_q)
            LOOP_NONE: begin
                if (only_start)            state_d = LOOP_ONE;   // enter
                else if (nl_write && wr_nl) ill_d  = 1'b1;       // reject
            end
            LOOP_ONE: begin
                if (only_start)            state_d = LOOP_TWO;   // nest
                else if (only_end)         state_d = LOOP_NONE;  // leave
                else if (nl_write && wr_nl) state_d = LOOP_TWO;  // nest by restore
            end
            LOOP_TWO: begin
                if (only_start)            ovf_set = 1'b1;       // overflow
                else if (only_end)         state_d = LOOP_ONE;   // unnest
                else if (nl_write && !wr_nl) state_d = LOOP_ONE; // unnest by restore
            end
            default:                       state_d = LOOP_NONE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LOOP_NONE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow_q <= 1'b0;
            illegal_q  <= 1'b0;
        end else begin
            overflow_q <= overflow_q | ovf_set;
            illegal_q  <= ill_d;
        end
    end

    // R4: the forbidden flag pair never appears
    a_r4_no_reserved_combo: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != loop_state_t'(2'b10));

    // R7: overflow error is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_q |=> overflow_q);

    // R7: third start keeps two loops and flags overflow
    a_r7_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (only_start && state_q == LOOP_TWO) |=> (state_q == LOOP_TWO && overflow_q));

    // R8: a repeat strobe alone leaves the loop state alone
    a_r8_rep_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_strobe && !do_start && !do_end && !wr_en) |=> $stable(state_q));

    // R10: illegal pulse only follows a nesting write with no loop active
    a_r10_illegal_source: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> $past(wr_en && wr_nl && state_q == LOOP_NONE));
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
    import opmode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_pin_a,
    input  logic        mode_pin_b,
    input  logic        reg_wr_en,
    input  logic [15:0] reg_wr_data,
    output logic [15:0] reg_rd_data,
    input  logic        do_start,
    input  logic        do_end,
    input  logic        rep_strobe,
    output logic [15:0] eff_mode,
    output logic        loop_flag,
    output logic        nest_flag,
    output logic [1:0]  loop_status,
    output logic        nest_overflow,
    output logic        nest_illegal
);
    logic [REG_W-1:0] cfg_q;
    loop_state_t      lstate;

    opmode_cfg_reg #(
        .W   (REG_W),
        .MSK (CFG_MSK)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_a   (mode_pin_a),
        .pin_b   (mode_pin_b),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .cfg_q   (cfg_q),
        .eff_q   (eff_mode)
    );

    opmode_loop_fsm u_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_start   (do_start),
        .do_end     (do_end),
        .rep_strobe (rep_strobe),
        .wr_en      (reg_wr_en),
        .wr_nl      (reg_wr_data[NL_BIT]),
        .state_q    (lstate),
        .overflow_q (nest_overflow),
        .illegal_q  (nest_illegal)
    );

    assign nest_flag   = lstate[1];
    assign loop_flag   = lstate[0];
    assign loop_status = lstate;

    always_comb begin
        reg_rd_data         = cfg_q;
        reg_rd_data[NL_BIT] = nest_flag;
    end
endmodule

// File: tb/test_opmode_ctrl.sv
module test_opmode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_pin_a = 1'b0, mode_pin_b = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] reg_rd_data;
    logic        do_start = 1'b0, do_end = 1'b0, rep_strobe = 1'b0;
    logic [15:0] eff_mode;
    logic        loop_flag, nest_flag, nest_overflow, nest_illegal;
    logic [1:0]  loop_status;

    always #4 clk = ~clk;

    opmode_ctrl i_opmode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_pin_a(mode_pin_a), .mode_pin_b(mode_pin_b),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .do_start(do_start), .do_end(do_end), .rep_strobe(rep_strobe),
        .eff_mode(eff_mode), .loop_flag(loop_flag), .nest_flag(nest_flag),
        .loop_status(loop_status), .nest_overflow(nest_overflow), .nest_illegal(nest_illegal)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected-value queues
    logic [15:0] q_rd[$];
    logic [15:0] q_eff[$];
    logic [1:0]  q_st[$];
    logic        q_ovf[$];
    logic        q_ill[$];
    string       q_tag[$];

    // reference model state
    logic [15:0] m_cfg = '0, m_eff = '0;
    logic        m_nl = 0, m_lf = 0, m_ovf = 0, m_ill = 0;

    task automatic push_exp(string tag);
        q_rd.push_back(m_cfg | {m_nl, 15'd0});
        q_eff.push_back(m_eff);
        q_st.push_back({m_nl, m_lf});
        q_ovf.push_back(m_ovf);
        q_ill.push_back(m_ill);
        q_tag.push_back(tag);
    endtask

    task automatic do_reset(string tag, logic pa, logic pb);
        @(negedge clk);
        rst_n = 0; mode_pin_a = pa; mode_pin_b = pb;
        reg_wr_en = 0; do_start = 0; do_end = 0; rep_strobe = 0;
        m_cfg = {14'd0, pb, pa}; m_eff = m_cfg;
        m_nl = 0; m_lf = 0; m_ovf = 0; m_ill = 0;
        push_exp(tag);
    endtask

    task automatic step(string tag, logic wr, logic [15:0] data,
                        logic st, logic en, logic rep);
        @(negedge clk);
        rst_n = 1; reg_wr_en = wr; reg_wr_data = data;
        do_start = st; do_end = en; rep_strobe = rep;
        mode_pin_a = ~mode_pin_a; mode_pin_b = ~mode_pin_b; // ignored after reset
        m_ill = 0;
        if (st && !en) begin
            if (m_nl) m_ovf = 1;
            else if (m_lf) m_nl = 1;
            else m_lf = 1;
        end else if (en && !st) begin
            if (m_nl) m_nl = 0;
            else m_lf = 0;
        end else if (!st && !en && wr) begin
            if (data[15] && !m_lf) m_ill = 1;
            else if (m_lf) m_nl = data[15];
        end
        m_eff = m_cfg;
        if (wr) m_cfg = data & 16'h017B;
        push_exp(tag);
    endtask

    task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: samples away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_tag.size() > 0) begin
                string t;
                t = q_tag.pop_front();
                cmp(t, "rd",  reg_rd_data, q_rd.pop_front());
                cmp(t, "eff", eff_mode,    q_eff.pop_front());
                cmp(t, "st",  {14'd0, loop_status}, {14'd0, q_st.pop_front()});
                cmp(t, "ovf", {15'd0, nest_overflow}, {15'd0, q_ovf.pop_front()});
                cmp(t, "ill", {15'd0, nest_illegal},  {15'd0, q_ill.pop_front()});
            end
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset pins b=1 a=0", 1'b0, 1'b1);
        do_reset("R1 reset held", 1'b0, 1'b1);
        step("R8 idle", 0, 16'h0, 0, 0, 0);
        step("R2 R10 write all ones, no loop", 1, 16'hFFFF, 0, 0, 0);
        step("R3 effective follows one cycle later", 0, 16'h0, 0, 0, 0);
        step("R5 enter one loop", 0, 16'h0, 1, 0, 0);
        step("R9 restore nest via write", 1, 16'h8000, 0, 0, 0);
        step("R3 effective after restore", 0, 16'h0, 0, 0, 0);
        step("R7 third start overflows", 0, 16'h0, 1, 0, 0);
        step("R7 overflow sticky", 0, 16'h0, 0, 0, 0);
        step("R6 unnest", 0, 16'h0, 0, 1, 0);
        step("R6 leave", 0, 16'h0, 0, 1, 0);
        step("R6 end with no loop", 0, 16'h0, 0, 1, 0);
        step("R8 rep strobe", 0, 16'h0, 0, 0, 1);
        step("R5 start one", 0, 16'h0, 1, 0, 0);
        step("R8 rep strobe in loop", 0, 16'h0, 0, 0, 1);
        step("R5 start two", 0, 16'h0, 1, 0, 0);
        step("R4 two loops status", 0, 16'h0, 0, 0, 0);
        step("R11 start+end together", 1, 16'h0030, 1, 1, 0);
        step("R9 write clears nest", 1, 16'h0108, 0, 0, 0);
        step("R11 end beats nl write", 1, 16'h8001, 0, 1, 0);
        step("R10 illegal nl write", 1, 16'h8040, 0, 0, 0);
        step("R10 pulse ends", 0, 16'h0, 0, 0, 0);
        do_reset("R1 reset pins both high", 1'b1, 1'b1);
        step("R1 after reset", 0, 16'h0, 0, 0, 0);
        step("R3 write then idle", 1, 16'h0002, 0, 0, 0);
        step("R3 effective catches up", 0, 16'h0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule